// File: doc/BRIEF.md
# Storage Controller Register File

This block is the host-visible register file of a storage controller. It sits on a simple 32-bit register bus with one request per cycle. Each request gets a registered response one cycle later. The block holds the read-only identity registers (capability, version), the interrupt mask, the controller configuration and status words, and the admin queue attribute and base address registers.

Writes into the doorbell window are decoded into a queue number and a direction, either submission tail or completion head. The block then raises a one-cycle doorbell event that carries the low half of the written value, so a command engine can act on it.

The block also runs the enable and shutdown handshakes:
- Turning the enable bit on raises the ready flag, and turning it off drops it.
- A normal shutdown request marks the shutdown status as complete.
- An abrupt shutdown request is refused with an error response.

Accesses that are not one full word, or that fall on no register, are answered with an error and change nothing.

Top module: `stor_ctl_regs`

## Requirements
- R1: Every request with `req_valid` high gets `rsp_valid` high exactly one cycle later. No response is produced in a cycle that follows an idle cycle. After reset, `rsp_valid`, `db_valid`, `cfg_en` and `sts_rdy` are 0.
- R2: The identity registers are read-only, and writes to them have no effect:
  - Offset 0x00 reads 0x0A010010: timeout 10 in bits 31:24, contiguous-queues flag in bit 16, maximum queue entries 0x0010 in bits 15:0.
  - Offset 0x04 reads 0.
  - Offset 0x08 reads 0x00010000.
- R3: The interrupt mask resets to 0. Writing ones at 0x0C sets those mask bits, and writing ones at 0x10 clears them. Both offsets read back the current mask.
- R4: The configuration word at 0x14 resets to 0 and keeps only the bits under mask 0x00FFFFF1:
  - enable in bit 0;
  - command set in bits 6:4;
  - page size in bits 10:7;
  - arbitration in bits 13:11;
  - shutdown request in bits 15:14;
  - queue entry sizes in bits 19:16 and 23:20.
  
  Reserved bits read 0, and `cfg_en` mirrors bit 0.
- R5: A configuration write that takes bit 0 from 0 to 1 sets the ready bit (status bit 0 and `sts_rdy`) and clears the shutdown status. A write that takes bit 0 from 1 to 0 clears the ready bit. Rewriting the same value of bit 0 leaves ready unchanged.
- R6: The shutdown request field (configuration bits 15:14) acts as follows:
  - Value 1 sets status bits 3:2 to 2'b10 (complete).
  - Value 0 leaves status bits 3:2 as they are.
  - Value 2 or 3 is refused with `rsp_err`, and the configuration and status words stay unchanged.
  
  The status word at 0x1C is read-only.
- R7: The admin attribute word at 0x24 keeps the bits under mask 0x0FFF0FFF. The admin queue base words are at 0x28/0x2C (submission, low/high) and 0x30/0x34 (completion, low/high). Writes to the low words clear bits 11:0.
- R8: A write to offset 0x1000 + 8*q + 4*c, for q below DB_QUEUES, raises `db_valid` for one cycle, starting one cycle after the request. The event carries `db_qid` = q, `db_is_cq` = c (offset bit 2) and `db_value` = write data bits 15:0.
- R9: An access is an error when its size is not 4 bytes (`req_size` counts bytes) or when its offset is unmapped. Unmapped offsets include any offset that is not a multiple of 4, offset 0x18, and offsets at or beyond 0x1000 + 8*DB_QUEUES. An error access gives `rsp_err` = 1 and `rsp_rdata` = 0, raises no doorbell event and changes no register.
- R10: Reads of the subsystem-reset word at 0x20 and of doorbell offsets return 0 without error. Writes to 0x20 are accepted and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| db_valid | output | 1 | Doorbell event, one cycle |
| db_qid | output | QID_W | Queue number of the doorbell |
| db_is_cq | output | 1 | 1 = completion head, 0 = submission tail |
| db_value | output | 16 | Low half of the doorbell write data |
| cfg_en | output | 1 | Current enable bit of the configuration word |
| sts_rdy | output | 1 | Current ready bit of the status word |

## Verification
Each result of a request appears at the clock edge that samples the request. This covers the response, the doorbell event, and the new `cfg_en`/`sts_rdy` levels. A read issued in the following cycle already sees the updated register.

The bench drives a request at a falling edge and keeps a behavioural model of every register. At the next falling edge it compares all outputs against the model's prediction for that single edge. Idle cycles are compared the same way, so a late, early or repeated doorbell or response is caught.

// File: rtl/stor_regs_pkg.sv
package stor_regs_pkg;

    localparam logic [31:0] OFF_CAPL  = 32'h0000_0000;
    localparam logic [31:0] OFF_CAPH  = 32'h0000_0004;
    localparam logic [31:0] OFF_VER   = 32'h0000_0008;
    localparam logic [31:0] OFF_IMSET = 32'h0000_000C;
    localparam logic [31:0] OFF_IMCLR = 32'h0000_0010;
    localparam logic [31:0] OFF_CFG   = 32'h0000_0014;
    localparam logic [31:0] OFF_STS   = 32'h0000_001C;
    localparam logic [31:0] OFF_SSRST = 32'h0000_0020;
    localparam logic [31:0] OFF_AQATR = 32'h0000_0024;
    localparam logic [31:0] OFF_SQBL  = 32'h0000_0028;
    localparam logic [31:0] OFF_SQBH  = 32'h0000_002C;
    localparam logic [31:0] OFF_CQBL  = 32'h0000_0030;
    localparam logic [31:0] OFF_CQBH  = 32'h0000_0034;
    localparam logic [31:0] OFF_DBELL = 32'h0000_1000;

    localparam logic [31:0] CFG_KEEP   = 32'h00FF_FFF1;
    localparam logic [31:0] AQATR_KEEP = 32'h0FFF_0FFF;
    localparam logic [31:0] BASE_ALIGN = 32'hFFFF_F000;
    localparam logic [31:0] VER_WORD   = 32'h0001_0000;
    localparam logic [1:0]  SHUT_IDLE  = 2'b00;
    localparam logic [1:0]  SHUT_DONE  = 2'b10;
    localparam logic [1:0]  SHREQ_NORM = 2'd1;
    localparam logic [2:0]  WORD_BYTES = 3'd4;

    typedef enum logic [3:0] {
        SEL_CAPL, SEL_CAPH, SEL_VER, SEL_IMSET, SEL_IMCLR, SEL_CFG,
        SEL_STS, SEL_SSRST, SEL_AQATR, SEL_SQBL, SEL_SQBH, SEL_CQBL,
        SEL_CQBH, SEL_DBELL, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] imask;
        logic [31:0] cfg;
        logic        rdy;
        logic [1:0]  shut;
        logic [31:0] aqatr;
        logic [31:0] sqb_lo;
        logic [31:0] sqb_hi;
        logic [31:0] cqb_lo;
        logic [31:0] cqb_hi;
        logic        rsp_valid;
        logic        rsp_err;
        logic [31:0] rsp_rdata;
    } regs_t;

endpackage

// File: rtl/stor_addr_dec.sv
module stor_addr_dec
    import stor_regs_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DB_QUEUES = 2,
    localparam int QID_W    = (DB_QUEUES > 1) ? $clog2(DB_QUEUES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output reg_sel_e          sel,
    output logic              bad,
    output logic [QID_W-1:0]  db_qid,
    output logic              db_cq
);
    localparam logic [ADDR_W-1:0] DB_LO = ADDR_W'(OFF_DBELL);
    localparam logic [ADDR_W-1:0] DB_HI = ADDR_W'(OFF_DBELL + 32'(8 * DB_QUEUES));

    logic [ADDR_W-1:0] db_off;
    logic              in_db;

    always_comb begin
        db_off = addr - DB_LO;
        in_db  = (addr >= DB_LO) && (addr < DB_HI) && (addr[1:0] == 2'b00);
        db_qid = db_off[QID_W+2:3];
        db_cq  = db_off[2];
        if (in_db) begin
            sel = SEL_DBELL;
        end else begin
            case (addr)
                ADDR_W'(OFF_CAPL):  sel = SEL_CAPL;
                ADDR_W'(OFF_CAPH):  sel = SEL_CAPH;
                ADDR_W'(OFF_VER):   sel = SEL_VER;
                ADDR_W'(OFF_IMSET): sel = SEL_IMSET;
                ADDR_W'(OFF_IMCLR): sel = SEL_IMCLR;
                ADDR_W'(OFF_CFG):   sel = SEL_CFG;
                ADDR_W'(OFF_STS):   sel = SEL_STS;
                ADDR_W'(OFF_SSRST): sel = SEL_SSRST;
                ADDR_W'(OFF_AQATR): sel = SEL_AQATR;
                ADDR_W'(OFF_SQBL):  sel = SEL_SQBL;
                ADDR_W'(OFF_SQBH):  sel = SEL_SQBH;
                ADDR_W'(OFF_CQBL):  sel = SEL_CQBL;
                ADDR_W'(OFF_CQBH):  sel = SEL_CQBH;
                default:            sel = SEL_NONE;
            endcase
        end
        bad = (size != WORD_BYTES) || (sel == SEL_NONE);
    end
endmodule

// File: rtl/stor_db_event.sv
module stor_db_event #(
    parameter int QID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [QID_W-1:0] qid,
    input  logic             is_cq,
    input  logic [15:0]      value,
    output logic             ev_valid,
    output logic [QID_W-1:0] ev_qid,
    output logic             ev_is_cq,
    output logic [15:0]      ev_value
);
    typedef struct packed {
        logic             valid;
        logic [QID_W-1:0] qid;
        logic             is_cq;
        logic [15:0]      value;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d       = ev_q;
        ev_d.valid = fire;
        if (fire) begin
            ev_d.qid   = qid;
            ev_d.is_cq = is_cq;
            ev_d.value = value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign ev_valid = ev_q.valid;
    assign ev_qid   = ev_q.qid;
    assign ev_is_cq = ev_q.is_cq;
    assign ev_value = ev_q.value;
endmodule

// File: rtl/stor_ctl_regs.sv
module stor_ctl_regs
    import stor_regs_pkg::*;
#(
    parameter int          ADDR_W    = 13,
    parameter int          DB_QUEUES = 2,
    parameter logic [15:0] MAX_QENT  = 16'h0010,
    parameter logic [7:0]  TIMEOUT   = 8'd10,
    localparam int         QID_W     = (DB_QUEUES > 1) ? $clog2(DB_QUEUES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              db_valid,
    output logic [QID_W-1:0]  db_qid,
    output logic              db_is_cq,
    output logic [15:0]       db_value,
    output logic              cfg_en,
    output logic              sts_rdy
);
    localparam logic [31:0] CAP_LO_WORD = {TIMEOUT, 7'd0, 1'b1, MAX_QENT};
    localparam logic [31:0] CAP_HI_WORD = 32'h0;

    reg_sel_e         sel;
    logic             bad;
    logic [QID_W-1:0] dec_qid;
    logic             dec_cq;
    logic             db_fire;
    regs_t            r_d, r_q;

    stor_addr_dec #(.ADDR_W(ADDR_W), .DB_QUEUES(DB_QUEUES)) u_dec (
        .addr   (req_addr),
        .size   (req_size),
        .sel    (sel),
        .bad    (bad),
        .db_qid (dec_qid),
        .db_cq  (dec_cq)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = req_valid;
        r_d.rsp_err   = 1'b0;
        r_d.rsp_rdata = '0;
        db_fire       = 1'b0;
        if (req_valid) begin
            if (bad) begin
                r_d.rsp_err = 1'b1;
            end else if (!req_write) begin
                case (sel)
                    SEL_CAPL:             r_d.rsp_rdata = CAP_LO_WORD;
                    SEL_CAPH:             r_d.rsp_rdata = CAP_HI_WORD;
                    SEL_VER:              r_d.rsp_rdata = VER_WORD;
                    SEL_IMSET, SEL_IMCLR: r_d.rsp_rdata = r_q.imask;
                    SEL_CFG:              r_d.rsp_rdata = r_q.cfg;
                    SEL_STS:              r_d.rsp_rdata = {28'd0, r_q.shut, 1'b0, r_q.rdy};
                    SEL_AQATR:            r_d.rsp_rdata = r_q.aqatr;
                    SEL_SQBL:             r_d.rsp_rdata = r_q.sqb_lo;
                    SEL_SQBH:             r_d.rsp_rdata = r_q.sqb_hi;
                    SEL_CQBL:             r_d.rsp_rdata = r_q.cqb_lo;
                    SEL_CQBH:             r_d.rsp_rdata = r_q.cqb_hi;
                    default:              r_d.rsp_rdata = '0;
                endcase
            end else begin
                case (sel)
                    SEL_IMSET: r_d.imask = r_q.imask | req_wdata;
                    SEL_IMCLR: r_d.imask = r_q.imask & ~req_wdata;
                    SEL_CFG: begin
                        if (req_wdata[15]) begin
                            r_d.rsp_err = 1'b1;
                        end else begin
                            r_d.cfg = req_wdata & CFG_KEEP;
                            if (!r_q.cfg[0] && req_wdata[0]) begin
                                r_d.rdy  = 1'b1;
                                r_d.shut = SHUT_IDLE;
                            end else if (r_q.cfg[0] && !req_wdata[0]) begin
                                r_d.rdy = 1'b0;
                            end
                            if (req_wdata[15:14] == SHREQ_NORM) r_d.shut = SHUT_DONE;
                        end
                    end
                    SEL_AQATR: r_d.aqatr  = req_wdata & AQATR_KEEP;
                    SEL_SQBL:  r_d.sqb_lo = req_wdata & BASE_ALIGN;
                    SEL_SQBH:  r_d.sqb_hi = req_wdata;
                    SEL_CQBL:  r_d.cqb_lo = req_wdata & BASE_ALIGN;
                    SEL_CQBH:  r_d.cqb_hi = req_wdata;
                    SEL_DBELL: db_fire    = 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    stor_db_event #(.QID_W(QID_W)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (db_fire),
        .qid      (dec_qid),
        .is_cq    (dec_cq),
        .value    (req_wdata[15:0]),
        .ev_valid (db_valid),
        .ev_qid   (db_qid),
        .ev_is_cq (db_is_cq),
        .ev_value (db_value)
    );

    assign rsp_valid = r_q.rsp_valid;
    assign rsp_err   = r_q.rsp_err;
    assign rsp_rdata = r_q.rsp_rdata;
    assign cfg_en    = r_q.cfg[0];
    assign sts_rdy   = r_q.rdy;
endmodule

// File: rtl/stor_ctl_regs_chk.sv
module stor_ctl_regs_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              db_valid,
    input logic [15:0]       db_value,
    input logic              cfg_en,
    input logic              sts_rdy
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(32'h14);

    logic cfg_wr;
    assign cfg_wr = req_valid && req_write && (req_addr == CFG_A) && (req_size == 3'd4);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                            // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                          // R1
    AST_BAD_SIZE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 3'd4) |=> (rsp_err && rsp_rdata == 32'h0 && !db_valid)); // R9
    AST_RDY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdy) |-> $past(cfg_wr && req_wdata[0]));                   // R5
    AST_RDY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_rdy) |-> $past(cfg_wr && !req_wdata[0]));                  // R5
    AST_ABRUPT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && req_wdata[15]) |=> (rsp_err && $stable(cfg_en) && $stable(sts_rdy))); // R6
    AST_DB_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> ($past(req_valid && req_write) && db_value == $past(req_wdata[15:0]))); // R8
endmodule

bind stor_ctl_regs stor_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_stor_ctl_regs.sv
module sim_stor_ctl_regs;
    localparam int ADDR_W = 13;
    localparam int QID_W  = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_size = 3'd4;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err, db_valid, db_is_cq, cfg_en, sts_rdy;
    logic [31:0]       rsp_rdata;
    logic [QID_W-1:0]  db_qid;
    logic [15:0]       db_value;

    always #4 clk = ~clk;

    stor_ctl_regs u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_mask, m_cfg, m_aq, m_sql, m_sqh, m_cql, m_cqh;
    logic        m_rdy;
    logic [1:0]  m_shut;
    logic        e_err, e_db, e_cq;
    logic [31:0] e_rd;
    int          e_q;
    logic [15:0] e_val;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(bit wr, int a, int sz, logic [31:0] wd);
        bit known = 1;
        e_err = 0; e_rd = 0; e_db = 0; e_q = 0; e_cq = 0; e_val = 0;
        if (a >= 'h1000 && a < 'h1010 && a % 4 == 0) begin
            if (sz == 4 && wr) begin
                e_db = 1; e_q = (a - 'h1000) / 8; e_cq = ((a / 4) % 2) == 1; e_val = wd[15:0];
            end
        end else if (!(a inside {'h00,'h04,'h08,'h0C,'h10,'h14,'h1C,'h20,'h24,'h28,'h2C,'h30,'h34})) begin
            known = 0;
        end
        if (sz != 4 || !known) begin
            e_err = 1; e_db = 0;
        end else if (!wr) begin
            if (a == 'h00) e_rd = 32'h0A01_0010;
            if (a == 'h08) e_rd = 32'h0001_0000;
            if (a == 'h0C || a == 'h10) e_rd = m_mask;
            if (a == 'h14) e_rd = m_cfg;
            if (a == 'h1C) e_rd = {28'd0, m_shut, 1'b0, m_rdy};
            if (a == 'h24) e_rd = m_aq;
            if (a == 'h28) e_rd = m_sql;
            if (a == 'h2C) e_rd = m_sqh;
            if (a == 'h30) e_rd = m_cql;
            if (a == 'h34) e_rd = m_cqh;
        end else begin
            if (a == 'h0C) m_mask = m_mask | wd;
            if (a == 'h10) m_mask = m_mask & ~wd;
            if (a == 'h24) m_aq = wd & 32'h0FFF_0FFF;
            if (a == 'h28) m_sql = {wd[31:12], 12'h000};
            if (a == 'h2C) m_sqh = wd;
            if (a == 'h30) m_cql = {wd[31:12], 12'h000};
            if (a == 'h34) m_cqh = wd;
            if (a == 'h14) begin
                int shreq = wd[15:14];
                if (shreq >= 2) e_err = 1;
                else begin
                    if (m_cfg[0] == 0 && wd[0] == 1) begin m_rdy = 1; m_shut = 0; end
                    if (m_cfg[0] == 1 && wd[0] == 0) m_rdy = 0;
                    if (shreq == 1) m_shut = 2'b10;
                    m_cfg = wd & 32'h00FF_FFF1;
                end
            end
        end
    endtask

    task automatic compare(string tag, bit exp_rsp);
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(exp_rsp));
        chk(tag, "db_valid", 32'(db_valid), 32'(exp_rsp && e_db));
        chk(tag, "cfg_en", 32'(cfg_en), 32'(m_cfg[0]));
        chk(tag, "sts_rdy", 32'(sts_rdy), 32'(m_rdy));
        if (exp_rsp) begin
            chk(tag, "rsp_err", 32'(rsp_err), 32'(e_err));
            chk(tag, "rsp_rdata", rsp_rdata, e_rd);
            if (e_db) begin
                chk(tag, "db_qid", 32'(db_qid), 32'(e_q));
                chk(tag, "db_is_cq", 32'(db_is_cq), 32'(e_cq));
                chk(tag, "db_value", 32'(db_value), 32'(e_val));
            end
        end
    endtask

    task automatic access(string tag, bit wr, int a, int sz, logic [31:0] wd);
        req_valid = 1; req_write = wr; req_addr = ADDR_W'(a); req_size = 3'(sz); req_wdata = wd;
        model(wr, a, sz, wd);
        @(negedge clk);
        req_valid = 0;
        compare(tag, 1);
    endtask

    task automatic wr(string tag, int a, logic [31:0] wd); access(tag, 1, a, 4, wd); endtask
    task automatic rd(string tag, int a); access(tag, 0, a, 4, 32'h0); endtask

    task automatic idle(string tag);
        @(negedge clk);
        compare(tag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_mask = 0; m_cfg = 0; m_aq = 0; m_sql = 0; m_sqh = 0; m_cql = 0; m_cqh = 0;
        m_rdy = 0; m_shut = 0; e_db = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle("R1_reset");
        // identity and reset values
        rd("R2_caplo", 'h00); rd("R2_caphi", 'h04); rd("R2_ver", 'h08);
        wr("R2_ver_wr", 'h08, 32'hFFFF_FFFF); rd("R2_ver_after", 'h08);
        wr("R2_cap_wr", 'h00, 32'h1234_5678); rd("R2_cap_after", 'h00);
        rd("R4_cfg_reset", 'h14); rd("R5_sts_reset", 'h1C);
        // interrupt mask
        wr("R3_set", 'h0C, 32'h0000_00F5); rd("R3_rd_set", 'h0C);
        wr("R3_clr", 'h10, 32'h0000_0011); rd("R3_rd_clr", 'h10);
        wr("R3_set2", 'h0C, 32'h8000_0000); rd("R3_rd_set2", 'h0C);
        // configuration fields, enable off
        wr("R4_fields", 'h14, 32'hFFFF_3FFE); rd("R4_rd", 'h14); rd("R5_still_off", 'h1C);
        // enable rise, same value, fall
        wr("R5_en_on", 'h14, 32'h0046_0001); rd("R5_rdy_set", 'h1C);
        wr("R5_en_hold", 'h14, 32'h0046_0001); rd("R5_rdy_hold", 'h1C);
        // shutdown normal, then no-effect, then abrupt refused
        wr("R6_shn_norm", 'h14, 32'h0046_4001); rd("R6_sts_done", 'h1C);
        wr("R6_shn_none", 'h14, 32'h0046_0001); rd("R6_sts_kept", 'h1C);
        wr("R6_shn_abrupt", 'h14, 32'h0000_8000); rd("R6_cfg_kept", 'h14); rd("R6_sts_kept2", 'h1C);
        wr("R6_shn_rsvd", 'h14, 32'h0000_C001); rd("R6_cfg_kept3", 'h14);
        wr("R5_en_off", 'h14, 32'h0000_0000); rd("R5_rdy_clr", 'h1C);
        wr("R5_en_on_again", 'h14, 32'h0000_0001); rd("R5_shut_cleared", 'h1C);
        // admin attributes and bases
        wr("R7_aq", 'h24, 32'hFFFF_FFFF); rd("R7_aq_rd", 'h24);
        wr("R7_sql", 'h28, 32'hDEAD_BEEF); rd("R7_sql_rd", 'h28);
        wr("R7_sqh", 'h2C, 32'h0000_00AB); rd("R7_sqh_rd", 'h2C);
        wr("R7_cql", 'h30, 32'h1234_5FFF); rd("R7_cql_rd", 'h30);
        wr("R7_cqh", 'h34, 32'hCAFE_0001); rd("R7_cqh_rd", 'h34);
        // doorbells, back to back
        wr("R8_sq0", 'h1000, 32'hABCD_0007);
        wr("R8_cq0", 'h1004, 32'h0000_0003);
        wr("R8_sq1", 'h1008, 32'h0001_FFFF);
        wr("R8_cq1", 'h100C, 32'h0000_0010);
        idle("R8_one_cycle");
        // reads returning zero
        rd("R10_db_rd", 'h1008); rd("R10_ssrst_rd", 'h20);
        wr("R10_ssrst_wr", 'h20, 32'h4E56_4D65); rd("R10_cfg_after", 'h14); rd("R10_aq_after", 'h24);
        // errors
        access("R9_size2", 1, 'h24, 2, 32'h0000_0001); rd("R9_aq_kept", 'h24);
        access("R9_size1_rd", 0, 'h00, 1, 32'h0);
        wr("R9_off18", 'h18, 32'h1); rd("R9_off18_rd", 'h18);
        wr("R9_misalign", 'h15, 32'h0); rd("R9_cfg_kept", 'h14);
        wr("R9_db_beyond", 'h1010, 32'h5); idle("R9_no_db");
        wr("R9_db_misalign", 'h1002, 32'h5);
        access("R9_db_size", 1, 'h1000, 2, 32'h5);
        rd("R9_hole", 'h0FFC);
        idle("R1_idle_end");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule